// File: doc/BRIEF.md
# Stable Marked-Element Packing Unit

This block takes a fixed-size array of data elements, each with a flag bit, and produces a reordered copy of the array. Flagged elements go to the front and unflagged elements go to the back. Within each group, elements keep the order they had on input. The block finds each element's output slot from two running counts. One count runs over the flag bits. The other runs over the inverted flag bits, and the total number of flagged elements is added to it as an offset. The block then moves every element to its slot in one scatter step.

A client places the data and flag vectors on the inputs and pulses `start` for one cycle. The operation runs through four steps: capture the inputs, form the running counts, register the flagged total, and scatter. At the end the packed vector and the flagged total are presented and `done` pulses for one cycle. Both results stay unchanged until the next operation completes. A `start` that arrives while an operation is running is ignored.

Top module: `pack_unit`

## Requirements
- R1: In the packed output, slot k (data bits k*W+W-1 down to k*W, with slot 0 at the least significant end) holds, for k < m, the (k+1)-th flagged input element counted from slot 0 upward. Here m is the number of set bits in `mark_in`, and bit i of `mark_in` flags input element i.
- R2: Output slots m to N-1 hold the unflagged input elements, in increasing order of their input index.
- R3: `marked_count` equals the number of set bits in the captured flag vector. It is never greater than N.
- R4: When `start` is sampled high in the idle state, `done` is high for exactly one cycle, starting after the fourth rising edge counted from the edge that sampled `start`. It is low in every other cycle.
- R5: An input with every flag set, or with no flag set, comes out in its original order.
- R6: A `start` pulse that arrives while an operation is running is ignored. Neither its data nor its flags affect the result being computed.
- R7: `packed_out` and `marked_count` change only in the cycle in which `done` is high. They hold their values at all other times.
- R8: While reset is asserted and after it is released, `done` is 0, `packed_out` is all zeros and `marked_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin packing |
| data_in | input | N*W | Input elements; element i at bits i*W+W-1 down to i*W |
| mark_in | input | N | Flag bits; bit i flags element i |
| packed_out | output | N*W | Packed elements, same slot layout as data_in |
| marked_count | output | $clog2(N+1) | Number of flagged elements |
| done | output | 1 | One-cycle pulse when the results are valid |

## Verification
The bench drives directed cases: every element flagged, no element flagged, a single flag at the highest index, and a single flag at index 0. A design that confused the two offsets, or left out the conversion from 1-based to 0-based slots, would rotate the array or drop an element off one end in these cases. Alternating and random flag patterns expose an unstable scatter, which shows up as swapped elements within a group. A second `start` is injected in the middle of an operation to catch a controller that restarts or recaptures its inputs. The bench also samples `done` on every cycle of an operation, so a pulse that comes early, comes late, or lasts two cycles is reported.

// File: rtl/pack_pkg.sv
package pack_pkg;
  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_COUNT = 2'd1,
    PK_BCAST = 2'd2,
    PK_SCAT  = 2'd3
  } pk_state_e;
endpackage

// File: rtl/pack_prefix.sv
// Inclusive running count of set bits, one count per position.
module pack_prefix #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]    bits_i,
  output logic [N*CW-1:0] incl_o
);
  logic [CW-1:0] cnt [N];

  for (genvar g = 0; g < N; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign cnt[g] = CW'(bits_i[g]);
    end else begin : g_rest
      assign cnt[g] = cnt[g-1] + CW'(bits_i[g]);
    end
    assign incl_o[g*CW +: CW] = cnt[g];
  end
endmodule

// File: rtl/pack_dest.sv
// Turns 1-based running counts into 0-based output slot indices.
module pack_dest #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]    flag_i,
  input  logic [N*CW-1:0] cnt_set_i,
  input  logic [N*CW-1:0] cnt_clr_i,
  input  logic [CW-1:0]   total_i,
  output logic [N*IW-1:0] slot_o
);
  logic [CW-1:0] pos_v;

  always_comb begin
    slot_o = '0;
    pos_v  = '0;
    for (int i = 0; i < N; i++) begin
      if (flag_i[i]) begin
        pos_v = cnt_set_i[i*CW +: CW] - CW'(1);
      end else begin
        pos_v = total_i + cnt_clr_i[i*CW +: CW] - CW'(1);
      end
      slot_o[i*IW +: IW] = pos_v[IW-1:0];
    end
  end
endmodule

// File: rtl/pack_scatter.sv
// Moves each element to its computed slot in one step.
module pack_scatter #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [N*W-1:0]  elem_i,
  input  logic [N*IW-1:0] slot_i,
  output logic [N*W-1:0]  elem_o
);
  always_comb begin
    elem_o = '0;
    for (int i = 0; i < N; i++) begin
      elem_o[int'(slot_i[i*IW +: IW])*W +: W] = elem_i[i*W +: W];
    end
  end
endmodule

// File: rtl/pack_ctrl.sv
// Sequencer: capture, count, register the total, scatter.
module pack_ctrl
  import pack_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  output logic      ld_in_o,
  output logic      ld_cnt_o,
  output logic      ld_tot_o,
  output logic      ld_out_o,
  output pk_state_e state_o
);
  pk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PK_IDLE:  if (start_i) st_d = PK_COUNT;
      PK_COUNT: st_d = PK_BCAST;
      PK_BCAST: st_d = PK_SCAT;
      PK_SCAT:  st_d = PK_IDLE;
      default:  st_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PK_IDLE;
    else        st_q <= st_d;
  end

  assign ld_in_o  = (st_q == PK_IDLE) && start_i;
  assign ld_cnt_o = (st_q == PK_COUNT);
  assign ld_tot_o = (st_q == PK_BCAST);
  assign ld_out_o = (st_q == PK_SCAT);
  assign state_o  = st_q;
endmodule

// File: rtl/pack_unit.sv
module pack_unit
  import pack_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N*W-1:0]   data_in,
  input  logic [N-1:0]     mark_in,
  output logic [N*W-1:0]   packed_out,
  output logic [CW-1:0]    marked_count,
  output logic             done
);
  logic      ld_in, ld_cnt, ld_tot, ld_out;
  pk_state_e state;

  logic [N*W-1:0]  data_q;
  logic [N-1:0]    mark_q;
  logic [N*CW-1:0] cset_d, cclr_d, cset_q, cclr_q;
  logic [CW-1:0]   tot_q;
  logic [N*IW-1:0] slot_d;
  logic [N*W-1:0]  pack_d, pack_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;

  pack_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .ld_in_o (ld_in),
    .ld_cnt_o(ld_cnt),
    .ld_tot_o(ld_tot),
    .ld_out_o(ld_out),
    .state_o (state)
  );

  pack_prefix #(.N(N), .CW(CW)) u_pre_set (.bits_i(mark_q),  .incl_o(cset_d));
  pack_prefix #(.N(N), .CW(CW)) u_pre_clr (.bits_i(~mark_q), .incl_o(cclr_d));

  pack_dest #(.N(N), .CW(CW), .IW(IW)) u_dest (
    .flag_i   (mark_q),
    .cnt_set_i(cset_q),
    .cnt_clr_i(cclr_q),
    .total_i  (tot_q),
    .slot_o   (slot_d)
  );

  pack_scatter #(.N(N), .W(W), .IW(IW)) u_scat (
    .elem_i(data_q),
    .slot_i(slot_d),
    .elem_o(pack_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= '0;
    end else if (ld_in) begin
      data_q <= data_in;
      mark_q <= mark_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cset_q <= '0;
      cclr_q <= '0;
    end else if (ld_cnt) begin
      cset_q <= cset_d;
      cclr_q <= cclr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (ld_tot) tot_q <= cset_q[(N-1)*CW +: CW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pack_q <= '0;
      cnt_q  <= '0;
    end else if (ld_out) begin
      pack_q <= pack_d;
      cnt_q  <= tot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= ld_out;
  end

  assign packed_out   = pack_q;
  assign marked_count = cnt_q;
  assign done         = done_q;
endmodule

// File: rtl/pack_unit_chk.sv
module pack_unit_chk #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic [N*W-1:0] packed_out,
  input logic [CW-1:0]  marked_count,
  input logic [N-1:0]   mark_q
);
  // R4: done never lasts two cycles
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: results hold outside the done cycle
  assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(packed_out) && $stable(marked_count)));

  // R3: reported total matches the captured flags
  assert_count_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(marked_count) == $countones(mark_q)));

  // R3: total bounded by the element count
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(marked_count) <= N);
endmodule

bind pack_unit pack_unit_chk #(.N(N), .W(W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .packed_out  (packed_out),
  .marked_count(marked_count),
  .mark_q      (mark_q)
);

// File: tb/sim_pack_unit.sv
module sim_pack_unit;
  localparam int N = 8;
  localparam int W = 8;
  localparam int CW = $clog2(N + 1);
  localparam int CLK_PERIOD = 10;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [N*W-1:0]   data_in;
  logic [N-1:0]     mark_in;
  logic [N*W-1:0]   packed_out;
  logic [CW-1:0]    marked_count;
  logic             done;

  int checks = 0;
  int failures = 0;

  pack_unit #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .mark_in(mark_in), .packed_out(packed_out),
    .marked_count(marked_count), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N*W-1:0] ref_pack(input logic [N*W-1:0] d,
                                              input logic [N-1:0] f);
    logic [N*W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < N; i++) if (f[i])  begin r[k*W +: W] = d[i*W +: W]; k++; end
    for (int i = 0; i < N; i++) if (!f[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
    return r;
  endfunction

  function automatic int ref_count(input logic [N-1:0] f);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (f[i]) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally injects a busy start with other inputs.
  task automatic run_op(input logic [N*W-1:0] d, input logic [N-1:0] f,
                        input bit inject, input string req);
    logic [N*W-1:0] exp_p;
    int exp_c;
    exp_p = ref_pack(d, f);
    exp_c = ref_count(f);
    @(negedge clk);
    data_in = d;
    mark_in = f;
    start = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (inject && k == 2) begin
        start = 1'b1;
        data_in = ~d;
        mark_in = ~f;
      end
      if (k == 4) begin
        check(done === 1'b1, "R4 done at cycle 4", {63'd0, done}, 1);
        check(packed_out === exp_p, req, packed_out, exp_p);
        check(int'(marked_count) == exp_c, "R3 count",
              N*W'(marked_count), N*W'(exp_c));
      end else begin
        check(done === 1'b0, "R4 done low", {63'd0, done}, 0);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N*W-1:0] d;
    logic [N-1:0]   f;
    logic [N*W-1:0] hold_p;
    d = '0;
    f = '0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    start = 1'b0;
    data_in = '0;
    mark_in = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(done === 1'b0 && packed_out === '0 && marked_count === '0,
          "R8 reset state", packed_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && packed_out === '0, "R8 after release", packed_out, '0);

    d = 64'h8877_6655_4433_2211;
    run_op(d, 8'hFF, 1'b0, "R5 all flagged");
    run_op(d, 8'h00, 1'b0, "R5 none flagged");
    run_op(d, 8'h55, 1'b0, "R1 R2 alternating");
    run_op(d, 8'h80, 1'b0, "R1 top flag only");
    run_op(d, 8'h01, 1'b0, "R2 bottom flag only");
    run_op(64'h0F0E_0D0C_0B0A_0908, 8'h3C, 1'b1, "R6 busy start ignored");

    hold_p = packed_out;
    repeat (6) @(negedge clk);
    check(packed_out === hold_p && done === 1'b0, "R7 hold", packed_out, hold_p);

    for (int t = 0; t < 200; t++) begin
      d = {$urandom, $urandom};
      f = N'($urandom);
      run_op(d, f, t[2], "R1 R2 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule